// File: doc/BRIEF.md
# Bit-Serial Multiply-Accumulate Lane

This block is a single lane of a bit-line compute array. It keeps an unsigned operand B in a small local bit store and holds a wide unsigned accumulator. On each request it adds the product A × B into the accumulator. A 1-bit full adder with a carry flip-flop does all of the arithmetic, one bit step per clock. Operand A reaches the lane one bit at a time over a serial broadcast wire at the start of every operation. The lane multiplies by AND-ing each A bit with the B bits, then shift-and-add. It then ripples the finished product into the accumulator, again one bit per clock.

A host loads B and clears the accumulator while the lane is idle. It pulses start and drives the A bits in the cycles that follow. It waits for the one-cycle done pulse before the next request. Sixty-four requests in a row form one dot-product term. The accumulator is N+M+6 bits wide, so such a run cannot overflow. The operand widths N and M are parameters and may be as small as one bit.

Top module: `bitserial_mac_lane`

## Requirements
- R1: After reset the accumulator reads zero and both busy and done are low.
- R2: A high acc_clear in an idle cycle sets the accumulator to zero at the next clock edge.
- R3: A high b_load in an idle cycle stores b_data as operand B. A b_load while busy is ignored, so the stored B stays unchanged.
- R4: The broadcast phase lasts N+5 cycles after the start edge. The a_bit values sampled at the first N rising edges after start are the bits of A, least significant bit first. a_bit is ignored during the last 5 cycles of the phase.
- R5: Each operation leaves the accumulator equal to (previous accumulator + A × B) modulo 2^(N+M+6), with A and B unsigned.
- R6: busy is high for exactly N+5 + N×M + (N+M+6) cycles after start is accepted. done is then high for exactly one cycle, in the first cycle in which busy is low.
- R7: start is ignored while busy. A request made during an operation neither restarts nor lengthens it.
- R8: Sixty-four operations in a row with both operands at their maximum values give exactly 64 × (2^N−1) × (2^M−1), with no wrap.
- R9: acc_clear is ignored while busy. The running sum is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one multiply-accumulate (accepted when idle) |
| a_bit | input | 1 | Serial broadcast of operand A, LSB first |
| b_load | input | 1 | Store b_data as operand B (idle only) |
| b_data | input | M | Operand B value |
| acc_clear | input | 1 | Zero the accumulator (idle only) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse at the end of an operation |
| acc_out | output | N+M+6 | Accumulator value |

## Verification
The hardest case to reach is a carry that leaves the top bit of one partial-product row. That bit must land in a product position that no earlier row has written. The accumulate ripple must also run through every one of the upper guard bits. Only operands with dense runs of ones force both of these, so the stimulus repeats maximum-value operands 64 times to push carries into the top accumulator bits. Randomized operands cover sparse carry patterns. A second hard case is a start, b_load or acc_clear in the middle of an operation. A poke mode raises all three together partway through the broadcast. The run that follows then shows whether any of them took effect.

// File: rtl/bitserial_mac_lane.sv
module bitserial_mac_lane #(
  parameter int N = 4,
  parameter int M = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             a_bit,
  input  logic             b_load,
  input  logic [M-1:0]     b_data,
  input  logic             acc_clear,
  output logic             busy,
  output logic             done,
  output logic [N+M+5:0]   acc_out
);
  localparam int PW    = N + M;
  localparam int K     = N + M + 6;
  localparam int CW    = $clog2(K);
  localparam int PIW   = $clog2(PW);
  localparam int JW    = $clog2(N + 1);
  localparam int IW    = $clog2(M + 1);
  localparam int TOTAL = (N + 5) + (N * M) + K;

  typedef enum logic [1:0] {S_IDLE, S_BCAST, S_PROD, S_ACC} state_t;

  state_t         st;
  logic [N-1:0]   a_reg;
  logic [M-1:0]   b_mem;
  logic [PW-1:0]  p;
  logic [K-1:0]   acc;
  logic [CW-1:0]  cnt;
  logic [JW-1:0]  rj;
  logic [IW-1:0]  ri;
  logic           carry;

  logic [N:0]     a_sh;
  logic [N-1:0]   a_shr;
  logic [M-1:0]   b_shr;
  logic [PIW-1:0] pidx, pnext;
  logic [K-1:0]   p_ext;
  logic           fa_x, fa_y, fa_s, fa_co;

  assign a_sh  = {a_bit, a_reg};
  assign a_shr = a_reg >> rj;
  assign b_shr = b_mem >> ri;
  assign pidx  = PIW'(rj) + PIW'(ri);
  assign pnext = pidx + 1'b1;
  assign p_ext = {{(K-PW){1'b0}}, p};

  always_comb begin
    fa_x = 1'b0;
    fa_y = 1'b0;
    case (st)
      S_PROD: begin
        fa_x = p[pidx];
        fa_y = a_shr[0] & b_shr[0];
      end
      S_ACC: begin
        fa_x = acc[cnt];
        fa_y = p_ext[cnt];
      end
      default: ;
    endcase
  end

  assign fa_s  = fa_x ^ fa_y ^ carry;
  assign fa_co = (fa_x & fa_y) | (carry & (fa_x ^ fa_y));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      a_reg <= '0;
      b_mem <= '0;
      p     <= '0;
      acc   <= '0;
      cnt   <= '0;
      rj    <= '0;
      ri    <= '0;
      carry <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (b_load)    b_mem <= b_data;
          if (acc_clear) acc   <= '0;
          if (start) begin
            st  <= S_BCAST;
            cnt <= '0;
            p   <= '0;
          end
        end
        S_BCAST: begin
          if (cnt < CW'(N)) a_reg <= a_sh[N:1];
          if (cnt == CW'(N + 4)) begin
            st    <= S_PROD;
            cnt   <= '0;
            ri    <= '0;
            rj    <= '0;
            carry <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PROD: begin
          p[pidx] <= fa_s;
          if (ri == IW'(M - 1)) begin
            p[pnext] <= fa_co;
            carry    <= 1'b0;
            ri       <= '0;
            if (rj == JW'(N - 1)) begin
              st  <= S_ACC;
              cnt <= '0;
            end else begin
              rj <= rj + 1'b1;
            end
          end else begin
            carry <= fa_co;
            ri    <= ri + 1'b1;
          end
        end
        S_ACC: begin
          acc[cnt] <= fa_s;
          if (cnt == CW'(K - 1)) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            carry <= fa_co;
            cnt   <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy    = (st != S_IDLE);
  assign acc_out = acc;

  int lat;
  always_ff @(posedge clk) begin
    if (!rst_n)    lat <= 0;
    else if (busy) lat <= lat + 1;
    else           lat <= 0;
  end

  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat == TOTAL));
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_b_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(b_mem));
  p_acc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_ACC && !(acc_clear && !busy)) |=> $stable(acc));
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_clear && !busy) |=> (acc_out == '0));
  p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

// File: tb/tb_bitserial_mac_lane.sv
`timescale 1ns/1ps
module tb_bitserial_mac_lane;
  localparam int N = 4;
  localparam int M = 4;
  localparam int K = N + M + 6;
  localparam int TOTAL = (N + 5) + N * M + K;
  localparam longint MASK = (64'd1 << K) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, a_bit = 1'b0, b_load = 1'b0, acc_clear = 1'b0;
  logic [M-1:0] b_data = '0;
  logic busy, done;
  logic [K-1:0] acc_out;

  int checks = 0;
  int errors = 0;
  longint model_acc = 0;
  int model_b = 0;
  int cyc_total = 0;

  bitserial_mac_lane #(.N(N), .M(M)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .a_bit(a_bit),
    .b_load(b_load), .b_data(b_data), .acc_clear(acc_clear),
    .busy(busy), .done(done), .acc_out(acc_out));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc_total <= cyc_total + 1;
    if (cyc_total == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc_total);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic load_b(input int b);
    @(negedge clk);
    b_load = 1'b1; b_data = M'(b);
    @(negedge clk);
    b_load = 1'b0;
    model_b = b;
  endtask

  task automatic clear_acc();
    @(negedge clk);
    acc_clear = 1'b1;
    @(negedge clk);
    acc_clear = 1'b0;
    model_acc = 0;
  endtask

  task automatic run_mac(input int a, input bit noise, input bit poke, input bit chk_lat);
    int t;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (t < 1000) begin
      if (done) break;
      if (t == 3 && poke) begin
        start = 1'b1; b_load = 1'b1; b_data = ~M'(model_b); acc_clear = 1'b1;
      end else begin
        start = 1'b0; b_load = 1'b0; acc_clear = 1'b0;
      end
      a_bit = (t < N) ? a[t] : noise;
      t = t + 1;
      @(negedge clk);
    end
    a_bit = 1'b0;
    model_acc = (model_acc + longint'(a) * longint'(model_b)) & MASK;
    if (chk_lat) begin
      check(t == TOTAL, "R6 busy length", t, TOTAL);
      check(done === 1'b1 && busy === 1'b0, "R6 done with busy low", {done, busy}, 2);
    end
    @(negedge clk);
    if (chk_lat) check(done === 1'b0, "R6 done one cycle", done, 0);
  endtask

  task automatic t_reset();
    check(acc_out == '0, "R1 reset acc", acc_out, 0);
    check(busy === 1'b0 && done === 1'b0, "R1 reset flags", {busy, done}, 0);
  endtask

  task automatic t_fixed();
    load_b(5); clear_acc();
    check(acc_out == '0, "R2 clear", acc_out, 0);
    run_mac(1, 1'b0, 1'b0, 1'b1);
    check(acc_out == K'(model_acc), "R5 a=1 b=5", acc_out, model_acc);
    run_mac(8, 1'b0, 1'b0, 1'b0);
    check(acc_out == K'(model_acc), "R4 msb order a=8", acc_out, model_acc);
    load_b(0);
    run_mac(15, 1'b0, 1'b0, 1'b0);
    check(acc_out == K'(model_acc), "R5 b=0", acc_out, model_acc);
    load_b(15);
    run_mac(0, 1'b0, 1'b0, 1'b0);
    check(acc_out == K'(model_acc), "R5 a=0", acc_out, model_acc);
    run_mac(15, 1'b0, 1'b0, 1'b0);
    check(acc_out == K'(model_acc), "R5 max", acc_out, model_acc);
  endtask

  task automatic t_guard();
    clear_acc(); load_b(11);
    run_mac(6, 1'b1, 1'b0, 1'b1);
    check(acc_out == K'(model_acc), "R4 guard bits ignored", acc_out, model_acc);
  endtask

  task automatic t_poke();
    clear_acc(); load_b(9);
    run_mac(7, 1'b0, 1'b0, 1'b0);
    run_mac(13, 1'b0, 1'b1, 1'b1);
    check(acc_out == K'(model_acc), "R9 clear while busy ignored", acc_out, model_acc);
    check(busy === 1'b0, "R7 start while busy ignored", busy, 0);
    run_mac(3, 1'b0, 1'b0, 1'b0);
    check(acc_out == K'(model_acc), "R3 load while busy ignored", acc_out, model_acc);
    load_b(6);
    run_mac(3, 1'b0, 1'b0, 1'b0);
    check(acc_out == K'(model_acc), "R3 idle load", acc_out, model_acc);
  endtask

  task automatic t_random64();
    clear_acc();
    for (int i = 0; i < 64; i++) begin
      if (i % 8 == 0) load_b(int'($urandom_range(0, (1 << M) - 1)));
      run_mac(int'($urandom_range(0, (1 << N) - 1)), 1'b0, 1'b0, 1'b0);
    end
    check(acc_out == K'(model_acc), "R5 random 64-term sum", acc_out, model_acc);
  endtask

  task automatic t_max64();
    longint exp;
    clear_acc(); load_b((1 << M) - 1);
    for (int i = 0; i < 64; i++) run_mac((1 << N) - 1, 1'b1, 1'b0, 1'b0);
    exp = 64 * ((1 << N) - 1) * ((1 << M) - 1);
    check(acc_out == K'(exp), "R8 64 max terms no wrap", acc_out, exp);
    run_mac((1 << N) - 1, 1'b0, 1'b0, 1'b1);
    check(acc_out == K'(model_acc), "R5 modulo continue", acc_out, model_acc);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fixed();
    t_guard();
    t_poke();
    t_random64();
    t_max64();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule